// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a small programmable logic array. It takes a 40-bit vector of true and complement input literals and builds eight product terms from it. Each term has its own inclusion mask and its own kill bit. The enabled data terms are ORed into a single sum. Four mode bits, two shared by every cell of the array and two owned by this cell, then set four things:

- whether the sum passes through a flip-flop or straight through;
- the polarity at the pad;
- where the pad's output enable comes from;
- which signal is returned to the array as feedback.

The pad is modelled as a value plus an enable. The surrounding logic resolves the tri-state, and the enclosing array uses the feedback output. The configuration inputs are assumed to stay static while the cell runs. A synchronous reset clears the flip-flop, which reproduces the power-up state.

This cell has no data stream, so it has no valid/ready handshake. Every pin is a plain level.

Top module: `sop_macrocell`

## Requirements
- R1: Product term i is the AND of every `and_in` bit whose bit is set in its mask slice `term_mask[i*40 +: 40]`. A term whose mask slice is all zero evaluates to 1.
- R2: When `term_off[i]` is 1, product term i is forced to 0, whatever its mask and inputs.
- R3: The sum is the OR of product terms 1 to 7, plus term 0 only when term 0 is not the output-enable source.
- R4: The mode bits decode as follows. `glb_mode[1]` is the registered-capable flag and `glb_mode[0]` is the complex flag. `loc_mode[1]` is the cell select bit and `loc_mode[0]` is the polarity bit. The decode is applied in this order:
  - `glb_mode[1]`=1 and `loc_mode[1]`=1 gives registered operation, external enable, and register feedback.
  - `glb_mode[1]`=1 and `loc_mode[1]`=0 gives combinatorial operation, term-0 enable, and own-pin feedback.
  - `glb_mode`=01 gives combinatorial operation, term-0 enable, and own-pin feedback.
  - `glb_mode`=00 and `loc_mode[1]`=1 gives a dedicated input: always disabled, with own-pin feedback.
  - `glb_mode`=00 and `loc_mode[1]`=0 gives a dedicated output: always enabled, with adjacent-pin feedback.
- R5: In registered operation, the flip-flop captures the sum on the rising clock edge, and `pad_out` changes only after that edge.
- R6: In combinatorial operation, `pad_out` follows the sum in the same cycle.
- R7: When `loc_mode[0]`=1, `pad_out` equals the selected value. When `loc_mode[0]`=0, `pad_out` is its inverse. The inversion is applied after the flip-flop.
- R8: `pad_oe` depends on the enable source:
  - external: `pad_oe` = NOT `ext_oe_n`;
  - term 0: `pad_oe` = product term 0;
  - always enabled: `pad_oe` = 1;
  - always disabled: `pad_oe` = 0.
- R9: `fb_out` depends on the feedback source:
  - own pin: `fb_out` = `pin_in`;
  - adjacent pin: `fb_out` = `adj_pin_in`;
  - register: `fb_out` = flip-flop content.
- R10: When `rst` is high on a clock edge, the flip-flop clears to 0. A registered cell with inverting polarity then drives `pad_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous clear of the flip-flop, active high |
| and_in | input | 40 | True/complement input literals |
| term_mask | input | 320 | Eight 40-bit inclusion masks, term i at bits i*40 upward |
| term_off | input | 8 | Per-term kill bits |
| glb_mode | input | 2 | Array-wide mode bits |
| loc_mode | input | 2 | Cell mode bits |
| ext_oe_n | input | 1 | External enable pin, active low |
| pin_in | input | 1 | Level sensed at this cell's pad |
| adj_pin_in | input | 1 | Level sensed at the neighbouring cell's pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback literal returned to the array |

## Verification
The hardest case to reach is product term 0 acting as the enable while it is also true. This must not leak into the sum. The stimulus therefore sets only the term-0 literal while every other live term is false, and checks that the pad shows a driven inactive level.

A second hard case is a disabled pad whose own-pin feedback must read the pulled-up level. The bench resolves the pad with a pull-up model and feeds it back into `pin_in`. Finally, capture timing is checked twice: the registered output is sampled once just after new inputs are applied, and again after the next edge.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {OE_EXT, OE_TERM, OE_ON, OE_OFF} oe_src_e;
  typedef enum logic [1:0] {FB_PIN, FB_ADJ, FB_REG} fb_src_e;

  typedef struct packed {
    logic    registered;
    logic    noninv;
    logic    pt0_is_oe;
    oe_src_e oe;
    fb_src_e fb;
  } arch_t;
endpackage

// File: rtl/sop_term_array.sv
module sop_term_array #(
  parameter int NIN   = 40,
  parameter int NTERM = 8
) (
  input  logic [NIN-1:0]       and_in,
  input  logic [NTERM*NIN-1:0] term_mask,
  input  logic [NTERM-1:0]     term_off,
  output logic [NTERM-1:0]     pt
);
  for (genvar i = 0; i < NTERM; i++) begin : g_term
    logic [NIN-1:0] sel_mask;
    logic [NIN-1:0] hit;
    assign sel_mask = term_mask[i*NIN +: NIN];
    // unmasked literals read as 1, so an empty mask yields a true term
    assign hit      = and_in | ~sel_mask;
    assign pt[i]    = ~term_off[i] & (&hit);
  end
endmodule

// File: rtl/sop_arch_decode.sv
module sop_arch_decode
  import sop_pkg::*;
(
  input  logic [1:0] glb_mode,
  input  logic [1:0] loc_mode,
  output arch_t      arch
);
  logic sync_f, cplx_f, sel_f;
  assign sync_f = glb_mode[1];
  assign cplx_f = glb_mode[0];
  assign sel_f  = loc_mode[1];

  always_comb begin
    arch.noninv     = loc_mode[0];
    arch.registered = 1'b0;
    arch.pt0_is_oe  = 1'b0;
    arch.oe         = OE_ON;
    arch.fb         = FB_ADJ;
    if (sync_f) begin
      if (sel_f) begin
        arch.registered = 1'b1;
        arch.oe         = OE_EXT;
        arch.fb         = FB_REG;
      end else begin
        arch.pt0_is_oe  = 1'b1;
        arch.oe         = OE_TERM;
        arch.fb         = FB_PIN;
      end
    end else if (cplx_f) begin
      arch.pt0_is_oe = 1'b1;
      arch.oe        = OE_TERM;
      arch.fb        = FB_PIN;
    end else if (sel_f) begin
      arch.oe = OE_OFF;
      arch.fb = FB_PIN;
    end
  end
endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage
  import sop_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sum,
  input  logic  pt0,
  input  arch_t arch,
  input  logic  ext_oe_n,
  input  logic  pin_in,
  input  logic  adj_pin_in,
  output logic  pad_out,
  output logic  pad_oe,
  output logic  fb_out
);
  logic q;
  logic core;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= sum;
  end

  assign core    = arch.registered ? q : sum;
  assign pad_out = arch.noninv ? core : ~core;

  always_comb begin
    unique case (arch.oe)
      OE_EXT:  pad_oe = ~ext_oe_n;
      OE_TERM: pad_oe = pt0;
      OE_ON:   pad_oe = 1'b1;
      default: pad_oe = 1'b0;
    endcase
  end

  always_comb begin
    unique case (arch.fb)
      FB_PIN:  fb_out = pin_in;
      FB_ADJ:  fb_out = adj_pin_in;
      default: fb_out = q;
    endcase
  end

  // R10: a reset edge leaves the flip-flop cleared
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == 1'b0));
  // R5: registered non-inverting pad shows the sum from the previous cycle
  a_r5_reg_capture: assert property (@(posedge clk) disable iff (rst)
    (arch.registered && arch.noninv) |=> (pad_out == $past(sum)));
  // R8: a dedicated input never drives its pad
  a_r8_oe_off: assert property (@(posedge clk) disable iff (rst)
    (arch.oe == OE_OFF) |-> !pad_oe);
  // R6: combinatorial pad tracks the sum within the cycle
  a_r6_comb_path: assert property (@(posedge clk) disable iff (rst)
    (!arch.registered) |-> (pad_out == (arch.noninv ? sum : ~sum)));
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int NIN   = 40,
  parameter int NTERM = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NIN-1:0]       and_in,
  input  logic [NTERM*NIN-1:0] term_mask,
  input  logic [NTERM-1:0]     term_off,
  input  logic [1:0]           glb_mode,
  input  logic [1:0]           loc_mode,
  input  logic                 ext_oe_n,
  input  logic                 pin_in,
  input  logic                 adj_pin_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 fb_out
);
  logic [NTERM-1:0] pt;
  logic [NTERM-1:0] data_sel;
  logic             or_sum;
  arch_t            arch;

  sop_term_array #(.NIN(NIN), .NTERM(NTERM)) u_terms (
    .and_in(and_in), .term_mask(term_mask), .term_off(term_off), .pt(pt)
  );

  sop_arch_decode u_decode (
    .glb_mode(glb_mode), .loc_mode(loc_mode), .arch(arch)
  );

  // term 0 is steered away from the OR gate while it serves as the enable
  assign data_sel = {{(NTERM-1){1'b1}}, ~arch.pt0_is_oe};
  assign or_sum   = |(pt & data_sel);

  sop_out_stage u_out (
    .clk(clk), .rst(rst), .sum(or_sum), .pt0(pt[0]), .arch(arch),
    .ext_oe_n(ext_oe_n), .pin_in(pin_in), .adj_pin_in(adj_pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  // R2: with every term killed the sum stays low
  a_r2_all_killed: assert property (@(posedge clk) disable iff (rst)
    (&term_off) |-> !or_sum);
  // R3: an enable-role term 0 alone never raises the sum
  a_r3_pt0_excluded: assert property (@(posedge clk) disable iff (rst)
    (arch.pt0_is_oe && pt[0] && (pt[NTERM-1:1] == '0)) |-> !or_sum);
endmodule

// File: tb/sop_macrocell_bench.sv
module sop_macrocell_bench;
  localparam int CLK_P = 10;
  localparam int NIN   = 40;
  localparam int NTERM = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NIN-1:0]       and_in = '0;
  logic [NTERM*NIN-1:0] term_mask = '0;
  logic [NTERM-1:0]     term_off = '1;
  logic [1:0]           glb_mode = 2'b10;
  logic [1:0]           loc_mode = 2'b10;
  logic                 ext_oe_n = 1'b0;
  logic                 pin_in;
  logic                 adj_pin_in = 1'b0;
  logic                 pad_out, pad_oe, fb_out;

  int checks = 0;
  int errors = 0;
  logic mq = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;
  // pad resolution with pull-up
  assign pin_in = pad_oe ? pad_out : 1'b1;

  sop_macrocell u_sop_macrocell (
    .clk(clk), .rst(rst), .and_in(and_in), .term_mask(term_mask),
    .term_off(term_off), .glb_mode(glb_mode), .loc_mode(loc_mode),
    .ext_oe_n(ext_oe_n), .pin_in(pin_in), .adj_pin_in(adj_pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  task automatic set_mask(input int t, input logic [NIN-1:0] m);
    term_mask[t*NIN +: NIN] = m;
  endtask

  // driver: compute expectation from the requirements and queue it
  task automatic step(input string tag);
    logic [NTERM-1:0] p;
    logic sum, reg_m, pt0oe, core, po, oe, pin, fb, nq;
    int oe_k, fb_k;
    for (int i = 0; i < NTERM; i++)
      p[i] = !term_off[i] &&
             ((and_in & term_mask[i*NIN +: NIN]) == term_mask[i*NIN +: NIN]);
    reg_m = 0; pt0oe = 0; oe_k = 2; fb_k = 1;
    if (glb_mode[1] && loc_mode[1]) begin reg_m = 1; oe_k = 0; fb_k = 2; end
    else if (glb_mode != 2'b00) begin pt0oe = 1; oe_k = 1; fb_k = 0; end
    else if (loc_mode[1]) begin oe_k = 3; fb_k = 0; end
    sum = 0;
    for (int i = 0; i < NTERM; i++)
      if (!(i == 0 && pt0oe)) sum = sum | p[i];
    nq   = rst ? 1'b0 : sum;
    core = reg_m ? nq : sum;
    po   = loc_mode[0] ? core : !core;
    case (oe_k)
      0: oe = !ext_oe_n;
      1: oe = p[0];
      2: oe = 1'b1;
      default: oe = 1'b0;
    endcase
    pin = oe ? po : 1'b1;
    case (fb_k)
      0: fb = pin;
      1: fb = adj_pin_in;
      default: fb = nq;
    endcase
    mq = nq;
    exp_q.push_back({po, oe, fb});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: pops after the edge that follows each drive
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pad_out, pad_oe, fb_out} !== e) begin
        errors++;
        $display("FAIL %s: got pad/oe/fb=%b expected %b", t,
                 {pad_out, pad_oe, fb_out}, e);
      end
    end
  end

  initial begin
    #(CLK_P*5000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10 reset, registered inverting, external enable low
    step("R10 reset state");
    rst = 0;
    set_mask(1, (40'd1 << 3) | (40'd1 << 5)); term_off[1] = 0;
    and_in = (40'd1 << 3) | (40'd1 << 5);
    #1;
    checks++;
    if (pad_out !== 1'b1) begin
      errors++;
      $display("FAIL R5 no early change: got %b expected 1", pad_out);
    end
    step("R5 R1 registered capture full match");
    and_in = 40'd1 << 3;
    step("R1 partial match gives 0");
    ext_oe_n = 1;
    step("R8 external enable high disables");
    ext_oe_n = 0; loc_mode = 2'b11; and_in = (40'd1 << 3) | (40'd1 << 5);
    step("R7 registered non-inverting");
    // complex combinatorial mode
    glb_mode = 2'b01; loc_mode = 2'b01; term_mask = '0; term_off = '1;
    set_mask(0, 40'd1); term_off[0] = 0;
    set_mask(1, 40'd2); term_off[1] = 0;
    and_in = 40'd3;
    step("R6 combinatorial same cycle");
    and_in = 40'd1;
    step("R3 term 0 as enable excluded from sum");
    and_in = 40'd2;
    step("R8 term 0 low disables, R9 pin pull-up");
    term_off[2] = 0; and_in = 40'd1;
    step("R1 empty mask term is true");
    term_off[2] = 1;
    step("R2 killed term forced low");
    // simple dedicated output
    glb_mode = 2'b00; loc_mode = 2'b00; term_off = '1; term_off[0] = 0;
    adj_pin_in = 1; and_in = 40'd1;
    step("R3 R9 term 0 as data, adjacent feedback high");
    adj_pin_in = 0;
    step("R9 adjacent feedback low");
    loc_mode = 2'b10;
    step("R4 R8 dedicated input pulled up");
    glb_mode = 2'b10; loc_mode = 2'b00;
    set_mask(1, 40'd4); term_off[1] = 0; and_in = 40'd5;
    step("R4 combinatorial cell in registered array");
    loc_mode = 2'b10; rst = 1;
    step("R10 reset mid-run drives pad high");
    rst = 0;
    @(negedge clk); @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule